// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps a 32-bit effective address onto a physical address using a small table of large, variable-size address blocks. Two independent tables exist: one serves instruction fetches, the other serves loads and stores. Each table entry is a pair of 32-bit words. The upper word holds the effective tag, a block-length mask and two privilege-valid bits. The lower word holds the physical block number and a two-bit protection code. Software loads the words through an index-addressed write port.

A request carries an effective address, an access kind and the privilege state. It enters through a valid/ready handshake. The block searches the chosen table, takes the lowest-numbered matching entry, and produces four results: a hit flag, the physical address, the granted read/write/execute rights and a protection-fault flag. The result is registered and comes out one cycle after the request is accepted, on a valid/ready handshake.

Back-pressure works as follows. The request side is ready whenever the response register is empty or is being drained in the same cycle. While a response is valid and the consumer holds its ready low, the response stays unchanged and no new request is taken.

Top module: `blk_xlate`

## Requirements
- R1: After reset every entry in both tables is invalid, `rsp_valid` is low and `req_ready` is high, so any request returns a miss.
- R2: The upper word uses bit 1 as the supervisor-valid bit and bit 0 as the user-valid bit. An entry takes part in the search only if its valid bit for the request's privilege is set (`req_user`=0 means supervisor, 1 means user).
- R3: The length field sits in upper-word bits 12:2. It masks effective-address bits 27:17. An entry matches when `req_ea[31:28]` equals upper-word bits 31:28 exactly, and when `req_ea[27:17]` ANDed with the inverted length field equals upper-word bits 27:17.
- R4: On a hit, `rsp_pa` is formed field by field:
  - bits 31:28 are lower-word bits 31:28;
  - bits 27:17 are (`req_ea[27:17]` AND length) OR lower-word bits 27:17;
  - bits 16:0 are `req_ea[16:0]`.
- R5: `req_kind` 2'b10 (fetch) searches the instruction table. Kinds 2'b00 (load), 2'b01 (store) and 2'b11 (treated as load) search the data table.
- R6: When several entries match, the lowest-indexed one supplies the result.
- R7: The protection code is lower-word bits 1:0, and `rsp_perm` is {read, write, execute}:
  - 00 grants nothing (3'b000);
  - 01 and 11 grant read and execute (3'b101);
  - 10 grants read, write and execute (3'b111).
- R8: On a hit, `rsp_fault` is set in three cases: a store lacks write, a fetch lacks execute, or a load (or kind 2'b11) lacks read. A miss never faults.
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted request appears on the response one cycle later. A response held by low `rsp_ready` stays stable.
- R10: On a miss, `rsp_hit`, `rsp_fault`, `rsp_perm` and `rsp_pa` are all zero.
- R11: A write with `cfg_we` high stores `cfg_wdata` into one word, chosen by three fields:
  - `cfg_iset` picks the table (1 = instruction);
  - `cfg_idx` picks the entry;
  - `cfg_upper` picks the word (1 = upper).

  Requests accepted in later cycles see the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table word write strobe |
| cfg_iset | input | 1 | Table select: 1 instruction, 0 data |
| cfg_idx | input | IDX_W | Entry index for the write |
| cfg_upper | input | 1 | Word select: 1 upper, 0 lower |
| cfg_wdata | input | 32 | Word value to store |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 as load |
| req_user | input | 1 | Privilege: 1 user, 0 supervisor |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | A table entry matched |
| rsp_fault | output | 1 | Matched entry forbids this access |
| rsp_perm | output | 3 | Granted rights {read, write, execute} |
| rsp_pa | output | 32 | Physical address |

## Verification
The checker assumes a consumer that eventually raises `rsp_ready`. It also assumes that table writes are not relied upon to alter a response that is already registered. The stability and offset-passthrough properties depend on both.

The bench drives requests and writes only on falling edges and holds `rsp_ready` high except in the dedicated stall sequence. During the stall it offers a different request, which must wait. Tag words in the length sweep are programmed both with and without masked bits set, so the exact-compare part of R3 is exercised from both sides. All request kinds used stay within the four defined encodings.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_ALT   = 2'b11
  } acc_e;

  typedef struct packed {
    logic       r;
    logic       w;
    logic       x;
  } perm_t;

  // Stored upper word: only the fields used by the match are kept
  typedef struct packed {
    logic [3:0]  tag_hi;
    logic [10:0] tag_lo;
    logic [10:0] len;
    logic        sup_ok;
    logic        usr_ok;
  } ent_hi_t;

  // Stored lower word
  typedef struct packed {
    logic [3:0]  pbn_hi;
    logic [10:0] pbn_lo;
    logic [1:0]  prot;
  } ent_lo_t;

  function automatic ent_hi_t unpack_hi(input logic [31:0] w);
    ent_hi_t e;
    e.tag_hi = w[31:28];
    e.tag_lo = w[27:17];
    e.len    = w[12:2];
    e.sup_ok = w[1];
    e.usr_ok = w[0];
    return e;
  endfunction

  function automatic ent_lo_t unpack_lo(input logic [31:0] w);
    ent_lo_t e;
    e.pbn_hi = w[31:28];
    e.pbn_lo = w[27:17];
    e.prot   = w[1:0];
    return e;
  endfunction

  function automatic perm_t decode_prot(input logic [1:0] p);
    perm_t g;
    unique case (p)
      2'b00:   g = '{r: 1'b0, w: 1'b0, x: 1'b0};
      2'b10:   g = '{r: 1'b1, w: 1'b1, x: 1'b1};
      default: g = '{r: 1'b1, w: 1'b0, x: 1'b1};
    endcase
    return g;
  endfunction

endpackage

// File: rtl/blkx_regfile.sv
module blkx_regfile
  import blkx_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic                    iset,
  input  logic [IDX_W-1:0]        idx,
  input  logic                    upper,
  input  logic [31:0]             wdata,
  output ent_hi_t [ENTRIES-1:0]   i_hi,
  output ent_lo_t [ENTRIES-1:0]   i_lo,
  output ent_hi_t [ENTRIES-1:0]   d_hi,
  output ent_lo_t [ENTRIES-1:0]   d_lo
);

  ent_hi_t wr_hi;
  ent_lo_t wr_lo;

  assign wr_hi = unpack_hi(wdata);
  assign wr_lo = unpack_lo(wdata);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic sel;
    assign sel = we && (idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        i_hi[e] <= '0;
        i_lo[e] <= '0;
        d_hi[e] <= '0;
        d_lo[e] <= '0;
      end else if (sel) begin
        if (iset && upper)   i_hi[e] <= wr_hi;
        if (iset && !upper)  i_lo[e] <= wr_lo;
        if (!iset && upper)  d_hi[e] <= wr_hi;
        if (!iset && !upper) d_lo[e] <= wr_lo;
      end
    end
  end

endmodule

// File: rtl/blkx_entry_match.sv
module blkx_entry_match
  import blkx_pkg::*;
(
  input  ent_hi_t     hi,
  input  ent_lo_t     lo,
  input  logic [31:0] ea,
  input  logic        user,
  output logic        hit,
  output logic [31:0] pa,
  output perm_t       perm
);

  logic        priv_ok;
  logic [10:0] ea_mid;

  always_comb begin
    ea_mid  = ea[27:17];
    priv_ok = user ? hi.usr_ok : hi.sup_ok;
    hit     = priv_ok
              && (ea[31:28] == hi.tag_hi)
              && ((ea_mid & ~hi.len) == hi.tag_lo);
    pa      = {lo.pbn_hi, (ea_mid & hi.len) | lo.pbn_lo, ea[16:0]};
    perm    = decode_prot(lo.prot);
  end

endmodule

// File: rtl/blkx_prio.sv
module blkx_prio
  import blkx_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic [ENTRIES-1:0]        hit_v,
  input  logic [ENTRIES-1:0][31:0]  pa_v,
  input  perm_t [ENTRIES-1:0]       perm_v,
  output logic                      any,
  output logic [31:0]               pa,
  output perm_t                     perm
);

  always_comb begin
    any  = 1'b0;
    pa   = '0;
    perm = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_v[i]) begin
        any  = 1'b1;
        pa   = pa_v[i];
        perm = perm_v[i];
      end
    end
  end

endmodule

// File: rtl/blk_xlate.sv
module blk_xlate
  import blkx_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_iset,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_upper,
  input  logic [31:0]      cfg_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_ea,
  input  logic [1:0]       req_kind,
  input  logic             req_user,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [2:0]       rsp_perm,
  output logic [31:0]      rsp_pa
);

  ent_hi_t [ENTRIES-1:0] i_hi, d_hi, s_hi;
  ent_lo_t [ENTRIES-1:0] i_lo, d_lo, s_lo;

  blkx_regfile #(.ENTRIES(ENTRIES)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .iset  (cfg_iset),
    .idx   (cfg_idx),
    .upper (cfg_upper),
    .wdata (cfg_wdata),
    .i_hi  (i_hi),
    .i_lo  (i_lo),
    .d_hi  (d_hi),
    .d_lo  (d_lo)
  );

  acc_e kind;
  assign kind = acc_e'(req_kind);

  always_comb begin
    if (kind == ACC_FETCH) begin
      s_hi = i_hi;
      s_lo = i_lo;
    end else begin
      s_hi = d_hi;
      s_lo = d_lo;
    end
  end

  logic [ENTRIES-1:0]       hit_v;
  logic [ENTRIES-1:0][31:0] pa_v;
  perm_t [ENTRIES-1:0]      perm_v;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_match
    blkx_entry_match u_match (
      .hi   (s_hi[e]),
      .lo   (s_lo[e]),
      .ea   (req_ea),
      .user (req_user),
      .hit  (hit_v[e]),
      .pa   (pa_v[e]),
      .perm (perm_v[e])
    );
  end

  logic        any_hit;
  logic [31:0] sel_pa;
  perm_t       sel_perm;

  blkx_prio #(.ENTRIES(ENTRIES)) u_prio (
    .hit_v  (hit_v),
    .pa_v   (pa_v),
    .perm_v (perm_v),
    .any    (any_hit),
    .pa     (sel_pa),
    .perm   (sel_perm)
  );

  logic deny;
  always_comb begin
    unique case (kind)
      ACC_STORE: deny = !sel_perm.w;
      ACC_FETCH: deny = !sel_perm.x;
      default:   deny = !sel_perm.r;
    endcase
  end

  logic accept;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_perm  <= '0;
      rsp_pa    <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= any_hit;
      rsp_fault <= any_hit && deny;
      rsp_perm  <= sel_perm;
      rsp_pa    <= sel_pa;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/blk_xlate_chk.sv
module blk_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_ea,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_hit,
  input logic        rsp_fault,
  input logic [2:0]  rsp_perm,
  input logic [31:0] rsp_pa
);

  assert_fault_on_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_hit);

  assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> (rsp_pa == 32'd0) && (rsp_perm == 3'd0) && !rsp_fault);

  assert_perm_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> (rsp_perm == 3'b000) || (rsp_perm == 3'b101) || (rsp_perm == 3'b111));

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_hit)
                                 && $stable(rsp_fault) && $stable(rsp_perm));

  assert_offset_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid
                              && (!rsp_hit || (rsp_pa[16:0] == $past(req_ea[16:0]))));

endmodule

bind blk_xlate blk_xlate_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_ea    (req_ea),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_hit   (rsp_hit),
  .rsp_fault (rsp_fault),
  .rsp_perm  (rsp_perm),
  .rsp_pa    (rsp_pa)
);

// File: tb/blk_xlate_tb.sv
`timescale 1ns/1ps
module blk_xlate_tb;

  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_iset = 1'b0, cfg_upper = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0, req_user = 1'b0, rsp_ready = 1'b1;
  logic [31:0] req_ea = '0;
  logic [1:0]  req_kind = '0;
  logic        req_ready, rsp_valid, rsp_hit, rsp_fault;
  logic [2:0]  rsp_perm;
  logic [31:0] rsp_pa;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] mu [2][N];
  logic [31:0] ml [2][N];

  always #2.5 clk = ~clk;

  blk_xlate #(.ENTRIES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_iset(cfg_iset),
    .cfg_idx(cfg_idx), .cfg_upper(cfg_upper), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
    .req_kind(req_kind), .req_user(req_user), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_perm(rsp_perm), .rsp_pa(rsp_pa)
  );

  // Expected {hit, fault, perm[2:0], pa[31:0]} from the requirements
  function automatic logic [36:0] expect_of(input logic [31:0] ea,
                                            input logic [1:0] kind,
                                            input logic user);
    int s;
    logic [36:0] r;
    s = (kind == 2'b10) ? 1 : 0;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      logic [31:0] u, l;
      logic [10:0] len;
      logic [2:0]  pm;
      logic        f;
      u = mu[s][i];
      l = ml[s][i];
      len = u[12:2];
      if ((user ? u[0] : u[1]) && ea[31:28] == u[31:28]
          && ((ea[27:17] & ~len) == u[27:17])) begin
        pm = (l[1:0] == 2'b00) ? 3'b000 : (l[1:0] == 2'b10) ? 3'b111 : 3'b101;
        if (kind == 2'b01)      f = !pm[1];
        else if (kind == 2'b10) f = !pm[0];
        else                    f = !pm[2];
        r = {1'b1, f, pm, l[31:28], (ea[27:17] & len) | l[27:17], ea[16:0]};
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [36:0] got, input logic [36:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input bit s, input int i, input bit up, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_iset = s; cfg_idx = 2'(i); cfg_upper = up; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (up) mu[s][i] = d; else ml[s][i] = d;
  endtask

  task automatic xl(input string tag, input logic [31:0] ea,
                    input logic [1:0] kind, input logic user);
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_kind = kind; req_user = user;
    @(negedge clk);
    req_valid = 1'b0;
    checks++;
    if (rsp_valid !== 1'b1) begin
      errors++;
      $display("FAIL R9 rsp_valid got=%b expected=1", rsp_valid);
    end
    check(tag, {rsp_hit, rsp_fault, rsp_perm, rsp_pa}, expect_of(ea, kind, user));
  endtask

  task automatic clear_all();
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < N; i++) begin
        wr(s[0], i, 1'b1, 32'd0);
        wr(s[0], i, 1'b0, 32'd0);
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < N; i++) begin mu[s][i] = '0; ml[s][i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 valid/ready got=%b%b expected=01", rsp_valid, req_ready);
    end
    xl("R1 empty table", 32'h0000_0000, 2'b00, 1'b0);
    xl("R1 empty table fetch", 32'h0000_1234, 2'b10, 1'b1);

    // R2 R5 R7 R8 R10: valid bits x protection x kind x privilege
    for (int vb = 0; vb < 4; vb++)
      for (int p = 0; p < 4; p++) begin
        wr(1'b0, 1, 1'b1, 32'h3000_0000 | 32'(vb));
        wr(1'b0, 1, 1'b0, 32'hA000_0000 | 32'(p));
        wr(1'b1, 1, 1'b1, 32'h3000_0000 | 32'(vb));
        wr(1'b1, 1, 1'b0, 32'hB000_0000 | 32'(p ^ 1));
        for (int k = 0; k < 4; k++)
          for (int u = 0; u < 2; u++)
            xl("R2 R5 R7 R8 R10 sweep", 32'h3001_5ABC, 2'(k), u[0]);
      end
    clear_all();

    // R3 R4: length mask sweep
    for (int li = 0; li < 5; li++) begin
      logic [10:0] len;
      logic [10:0] tl;
      len = (li == 0) ? 11'h000 : (li == 1) ? 11'h001 : (li == 2) ? 11'h00F :
            (li == 3) ? 11'h7FF : 11'h0F0;
      tl = (li == 4) ? 11'h5A3 : (11'h5A3 & ~len);
      wr(1'b0, 2, 1'b1, {4'h6, tl, 4'h0, len, 2'b11});
      wr(1'b0, 2, 1'b0, {4'h9, 11'h280 & ~len, 15'h0, 2'b10});
      for (int k = 0; k < 12; k++) begin
        logic [31:0] ea;
        ea = {(k % 4 == 3) ? 4'h7 : 4'h6, tl, 17'h0} ^ (32'(k) * 32'h0002_3C57);
        xl("R3 R4 length sweep", ea, 2'b01, 1'b0);
        xl("R3 R4 exact tag", {4'h6, tl, 17'(k * 4099)}, 2'b00, 1'b1);
      end
    end
    clear_all();

    // R6 R11: priority and rewrite
    wr(1'b0, 0, 1'b1, 32'h4000_0002);
    wr(1'b0, 0, 1'b0, 32'h1000_0002);
    wr(1'b0, 2, 1'b1, 32'h4000_0002);
    wr(1'b0, 2, 1'b0, 32'h2000_0001);
    xl("R6 lowest index wins", 32'h4000_0F00, 2'b00, 1'b0);
    checks++;
    if (rsp_pa[31:28] !== 4'h1) begin
      errors++;
      $display("FAIL R6 pa_hi got=%h expected=1", rsp_pa[31:28]);
    end
    wr(1'b0, 0, 1'b1, 32'h0);
    xl("R11 rewrite drops entry 0", 32'h4000_0F00, 2'b01, 1'b0);
    checks++;
    if (rsp_pa[31:28] !== 4'h2 || rsp_fault !== 1'b1) begin
      errors++;
      $display("FAIL R11 pa_hi/fault got=%h/%b expected=2/1", rsp_pa[31:28], rsp_fault);
    end
    xl("R5 instruction set untouched", 32'h4000_0F00, 2'b10, 1'b0);

    // R9: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_ea = 32'h4000_0123; req_kind = 2'b00; req_user = 1'b0;
    @(negedge clk);
    req_ea = 32'h4000_0456;
    repeat (2) begin
      checks++;
      if (req_ready !== 1'b0 || rsp_valid !== 1'b1 || rsp_pa !== 32'h2000_0123) begin
        errors++;
        $display("FAIL R9 stall got=%b%b %h expected=01 20000123", req_ready, rsp_valid, rsp_pa);
      end
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 queued request", {rsp_hit, rsp_fault, rsp_perm, rsp_pa},
          expect_of(32'h4000_0456, 2'b00, 1'b0));
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9 drain got=%b expected=0", rsp_valid);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule